// File: doc/BRIEF.md
# Energy Bin Event Classifier

This block serves one detector channel in a photon-counting readout. Eight clocked threshold comparators report whether the shaped pulse is above each of eight rising energy levels. The block samples them on the falling clock edge and latches every level that is reached, so that it holds the peak of the pulse. The lowest level starts an event. A programmable number of clocks later, past the pulse peak, the block picks the highest latched level and advances that level's counter. It then clears the latches, pulses the shaping-filter reset and ignores the comparators for a programmable holdoff.

Each of the eight per-bin counters is a maximal-length 8-bit linear feedback shift register, and the counts leave the block in that coded form. Two sticky flags track the current frame: a counter wrap and a comparator pattern that was not thermometer coded. A one-cycle snapshot request copies the counters and flags into holding registers and starts a new frame at once, so acquisition goes on while the held frame is read out.

Top module: `energy_bin_sorter`

## Requirements
- R1: `cmp_in` is sampled on the falling clock edge. Once an event has started, any level seen high on any falling edge up to the decision stays latched, even if it later drops.
- R2: An event starts only when level 0 (`cmp_in[0]`) is seen high while the block is idle. Higher levels without level 0 start nothing and count nothing.
- R3: With detection at rising edge E0, the decision comes at edge E0+`n1_cfg` (`n1_cfg` ≥ 1). Exactly one bin is advanced: the bin whose index is the highest level latched.
- R4: Each counter resets to 8'hFF and advances as s → {s[6:0], s[7]^s[5]^s[4]^s[3]}. Bin i sits at `held_cnt[8*i+7:8*i]`.
- R5: After the decision, the latches are cleared and `cmp_in` is ignored. The next event can be detected at the first edge after E0+max(`n1_cfg`+`n2_cfg`, `n1_cfg`+1, `nfr_cfg`).
- R6: `filt_rst` goes high after edge E0+`n1_cfg` and goes low after edge E0+max(`nfr_cfg`, `n1_cfg`+1).
- R7: `held_ovf` reports that, in the held frame, a counter stepped back into 8'hFF, which happens on its 255th event.
- R8: `held_therm` reports that, in the held frame, an event's latched pattern was not of the form 2^k−1 (k ones from bit 0 up, then zeros).
- R9: When `snap` is high at a rising edge, the counters and flags are copied to the held outputs and then restart from 8'hFF and 0.
- R10: When a snapshot and a decision fall on the same edge, the held frame excludes that event and the new frame contains it.
- R11: After reset, every held count reads 8'hFF, both held flags read 0 and `filt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; comparators sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | NBIN | Threshold comparator outputs, bit 0 lowest level |
| n1_cfg | input | NW | Clocks from detection to decision (≥ 1) |
| n2_cfg | input | NW | Holdoff clocks after the decision |
| nfr_cfg | input | NW | Minimum clocks from detection to filter-reset release |
| snap | input | 1 | Frame snapshot request, one cycle |
| filt_rst | output | 1 | Shaping-filter reset strobe |
| held_cnt | output | NBIN*CW | Held LFSR-coded counts, bin i at [CW*i +: CW] |
| held_ovf | output | 1 | Held counter-wrap flag |
| held_therm | output | 1 | Held non-thermometer-pattern flag |

## Verification
A snapshot request and a bin decision can fall on the same rising edge. The bench provokes this by raising `snap` so that it is sampled exactly on the decision edge of an event whose level differs from the one counted before it. It then takes a second snapshot and judges both: the first held frame must lack the event and the second must hold exactly that one count. The long wrap run also checks that the overflow flag of a full frame does not leak into the next frame.

// File: rtl/energy_bin_sorter.sv
module energy_bin_sorter #(
  parameter int NBIN = 8,
  parameter int CW   = 8,
  parameter int NW   = 8,
  parameter logic [CW-1:0] TAPS = 8'hB8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBIN-1:0]      cmp_in,
  input  logic [NW-1:0]        n1_cfg,
  input  logic [NW-1:0]        n2_cfg,
  input  logic [NW-1:0]        nfr_cfg,
  input  logic                 snap,
  output logic                 filt_rst,
  output logic [NBIN*CW-1:0]   held_cnt,
  output logic                 held_ovf,
  output logic                 held_therm
);
  localparam int AW = NW + 2;
  localparam int HW = (NBIN > 1) ? $clog2(NBIN) : 1;
  localparam logic [CW-1:0] ONES = '1;

  typedef enum logic [1:0] {IDLE, ARM, HOLD} st_t;

  st_t             st;
  logic [NBIN-1:0] cmp_s, cap, dv, bump, wrap;
  logic [AW-1:0]   age;
  logic [HW-1:0]   hi;
  logic            ovf_flag, therm_flag;

  // falling-edge comparator sampling
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cmp_s <= '0;
    else        cmp_s <= cmp_in;

  wire [AW-1:0] age_nx    = age + 1'b1;
  assign        dv        = cap | cmp_s;
  wire          decide    = (st == ARM) && (age_nx >= AW'(n1_cfg));
  wire          fr_done   = age_nx >= AW'(nfr_cfg);
  wire          hold_done = (age_nx >= AW'(n1_cfg) + AW'(n2_cfg)) && fr_done;
  wire          therm_bad = |(dv & (dv + 1'b1));

  always_comb begin
    hi = '0;
    for (int i = 0; i < NBIN; i++)
      if (dv[i]) hi = HW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= IDLE;
      age      <= '0;
      cap      <= '0;
      filt_rst <= 1'b0;
    end else begin
      case (st)
        IDLE: if (cmp_s[0]) begin
          st  <= ARM;
          age <= '0;
          cap <= cmp_s;
        end
        ARM: begin
          age <= age_nx;
          if (decide) begin
            cap      <= '0;
            st       <= HOLD;
            filt_rst <= 1'b1;
          end else cap <= dv;
        end
        default: begin
          age <= age_nx;
          if (fr_done)   filt_rst <= 1'b0;
          if (hold_done) st <= IDLE;
        end
      endcase
    end

  for (genvar g = 0; g < NBIN; g++) begin : g_bin
    logic [CW-1:0] c_q, h_q;
    wire  [CW-1:0] c_nx  = {c_q[CW-2:0], ^(c_q & TAPS)};
    wire  [CW-1:0] c_rst = {ONES[CW-2:0], ^(ONES & TAPS)};
    assign bump[g] = decide && (hi == HW'(g));
    assign wrap[g] = bump[g] && !snap && (c_nx == ONES);
    assign held_cnt[g*CW +: CW] = h_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        c_q <= ONES;
        h_q <= ONES;
      end else if (snap) begin
        h_q <= c_q;
        c_q <= bump[g] ? c_rst : ONES;
      end else if (bump[g]) c_q <= c_nx;

    a_r4_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n) c_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      therm_flag <= 1'b0;
      held_ovf   <= 1'b0;
      held_therm <= 1'b0;
    end else if (snap) begin
      held_ovf   <= ovf_flag;
      held_therm <= therm_flag;
      ovf_flag   <= 1'b0;
      therm_flag <= decide && therm_bad;
    end else begin
      ovf_flag   <= ovf_flag | (|wrap);
      therm_flag <= therm_flag | (decide && therm_bad);
    end

  a_r2_idle_quiet:      assert property (@(posedge clk) disable iff (!rst_n)
                          st == IDLE |-> !filt_rst && cap == '0);
  a_r3_bump_needs_cap0: assert property (@(posedge clk) disable iff (!rst_n)
                          |bump |-> cap[0]);
  a_r5_hold_cleared:    assert property (@(posedge clk) disable iff (!rst_n)
                          st == HOLD |-> cap == '0);
  a_r6_rise_in_hold:    assert property (@(posedge clk) disable iff (!rst_n)
                          $rose(filt_rst) |-> st == HOLD);
  a_r7_ovf_sticky:      assert property (@(posedge clk) disable iff (!rst_n)
                          ovf_flag && !snap |=> ovf_flag);
  a_r9_snap_clears:     assert property (@(posedge clk) disable iff (!rst_n)
                          snap && !decide |=> !ovf_flag && !therm_flag);
endmodule

// File: tb/energy_bin_sorter_tb.sv
`timescale 1ns/1ps
module energy_bin_sorter_tb;
  logic        clk = 1'b0, rst_n = 1'b0, snap = 1'b0;
  logic [7:0]  cmp = '0, n1_cfg = 8'd4, n2_cfg = 8'd3, nfr_cfg = 8'd6;
  logic        filt_rst, held_ovf, held_therm;
  logic [63:0] held_cnt;

  energy_bin_sorter u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp), .n1_cfg(n1_cfg), .n2_cfg(n2_cfg),
    .nfr_cfg(nfr_cfg), .snap(snap), .filt_rst(filt_rst), .held_cnt(held_cnt),
    .held_ovf(held_ovf), .held_therm(held_therm));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tbl [255];
  int cnt_m [8];
  bit ovf_m = 0, th_m = 0;

  typedef struct { logic [63:0] c; logic o; logic t; } exp_t;
  exp_t  sbq [$];
  string tagq [$];
  event  mon_go;

  function automatic logic [7:0] step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver side: push expected held frame, restart model frame
  task automatic push_expect(input string tag);
    exp_t x;
    for (int i = 0; i < 8; i++) x.c[i*8 +: 8] = tbl[cnt_m[i] % 255];
    x.o = ovf_m; x.t = th_m;
    sbq.push_back(x); tagq.push_back(tag);
    for (int i = 0; i < 8; i++) cnt_m[i] = 0;
    ovf_m = 0; th_m = 0;
  endtask

  // monitor: compare held outputs against the scoreboard
  initial forever begin
    exp_t x; string tg;
    @(mon_go);
    if (sbq.size() == 0) chk(0, "scoreboard empty", 0, 0);
    else begin
      x = sbq.pop_front(); tg = tagq.pop_front();
      chk(held_cnt === x.c, {tg, " R3 R4 R9 counts"}, held_cnt, x.c);
      chk(held_ovf === x.o, {tg, " R7 overflow"}, 64'(held_ovf), 64'(x.o));
      chk(held_therm === x.t, {tg, " R8 thermometer"}, 64'(held_therm), 64'(x.t));
    end
  end

  task automatic take_snap(input string tag);
    @(posedge clk); #1;
    push_expect(tag); snap = 1'b1;
    @(posedge clk); #1;
    snap = 1'b0;
    #2 -> mon_go;
  endtask

  // one event: pa from start, pb after edge ta, zero after edge hold
  task automatic ev(input logic [7:0] pa, pb, input int ta, hold, snap_at);
    int n1, n2, nfr, j, t_end, b, k;
    logic [7:0] cur, seen;
    n1 = int'(n1_cfg); n2 = int'(n2_cfg); nfr = int'(nfr_cfg);
    j = (nfr > n1 + 1) ? nfr : n1 + 1;
    t_end = 1 + ((n1 + n2 > j) ? n1 + n2 : j);
    @(posedge clk); #1;
    cur = pa; cmp = cur; seen = cur;
    if (snap_at == 1) begin push_expect("R10 coincident"); snap = 1'b1; end
    for (int e = 1; e <= t_end; e++) begin
      @(posedge clk); #1;
      if (snap) snap = 1'b0;
      if (e == ta) cur = pb;
      if (e >= hold) cur = '0;
      cmp = cur;
      if (e <= n1) seen |= cur;
      if (e + 1 == snap_at) begin push_expect("R10 coincident"); snap = 1'b1; end
      #2;
      if (e == snap_at) -> mon_go;
      chk(filt_rst === ((e >= 1 + n1) && (e < 1 + j)), "R6 filter reset",
          64'(filt_rst), 64'((e >= 1 + n1) && (e < 1 + j)));
    end
    b = 0; k = 0;
    for (int i = 0; i < 8; i++) begin
      if (seen[i]) b = i;
      k += int'(seen[i]);
    end
    if (seen != 8'((1 << k) - 1)) th_m = 1;
    if ((cnt_m[b] + 1) % 255 == 0) ovf_m = 1;
    cnt_m[b]++;
  endtask

  task automatic ev1(input logic [7:0] p);
    ev(p, p, 0, 1, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tbl[0] = 8'hFF;
    for (int i = 1; i < 255; i++) tbl[i] = step(tbl[i-1]);
    for (int i = 0; i < 8; i++) cnt_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    // R11 reset state
    chk(held_cnt === '1, "R11 held counts", held_cnt, '1);
    chk(held_ovf === 1'b0 && held_therm === 1'b0, "R11 held flags",
        64'({held_ovf, held_therm}), 0);
    chk(filt_rst === 1'b0, "R11 filter reset", 64'(filt_rst), 0);

    // R3 R4 basic binning
    ev1(8'h07); ev1(8'h01); ev1(8'hFF); ev1(8'h0F); ev1(8'h0F); ev1(8'h0F);
    take_snap("basic");
    // R1 sticky capture
    ev(8'h01, 8'h1F, 2, 3, 0);
    ev(8'h3F, 8'h01, 1, 4, 0);
    take_snap("R1 sticky");
    // R9 empty frame after snapshot
    take_snap("R9 empty");
    // R8 bad pattern, then cleared in the next frame
    ev1(8'h05);
    take_snap("R8 bad pattern");
    ev1(8'h03);
    take_snap("R8 cleared");
    // R2 higher levels without level 0
    @(posedge clk); #1 cmp = 8'h06;
    repeat (3) @(posedge clk);
    #1 cmp = '0;
    repeat (4) @(posedge clk);
    chk(filt_rst === 1'b0, "R2 no filter reset", 64'(filt_rst), 0);
    take_snap("R2 ignored");
    // R5 level 0 during holdoff ignored
    n1_cfg = 8'd2; n2_cfg = 8'd6; nfr_cfg = 8'd3;
    ev(8'h03, 8'h01, 3, 8, 0);
    ev1(8'h01);
    take_snap("R5 holdoff");
    // R6 long filter reset
    n1_cfg = 8'd3; n2_cfg = 8'd1; nfr_cfg = 8'd9;
    ev1(8'h01); ev1(8'h7F);
    take_snap("R6 long reset");
    // R10 snapshot on the decision edge
    n1_cfg = 8'd2; n2_cfg = 8'd2; nfr_cfg = 8'd4;
    ev1(8'h01);
    ev(8'h03, 8'h03, 0, 1, 3);
    take_snap("R10 new frame");
    // R7 wrap after 255 events
    n1_cfg = 8'd1; n2_cfg = 8'd0; nfr_cfg = 8'd0;
    for (int i = 0; i < 254; i++) ev1(8'h7F);
    take_snap("R7 254 events");
    for (int i = 0; i < 255; i++) ev1(8'h7F);
    take_snap("R7 255 events");
    ev1(8'h7F);
    take_snap("R7 flag restarts");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule